// File: doc/BRIEF.md
# Index-Addressed Interrupt Gate

This block sits between a vector of level-sensitive interrupt lines and a processor. Each line has one enable bit. Software never touches those bits with a read-modify-write sequence. It writes the number of one line to a "set" register to enable that line, or to a "clear" register to disable it. Disabling a line through the clear register is also how a handler acknowledges it. A write to either register affects that single line and no other.

The block drives one combined request, which is high while any enabled line is high. A read-only register returns the lowest-numbered line that is both high and enabled. That lets the handler dispatch without scanning the lines itself. Two read-only words return the enable bits for inspection. Read data is combinational from the address. Writes take effect on the clock edge where the write strobe is sampled.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0. With all source lines high, `irq_req` is 0, both enable words read 0 and the first-pending register reads 0x8000_0000.
- R2: A write to offset 0x08 whose data is a source number N below 64 sets enable bit N at that clock edge and changes no other enable bit.
- R3: A write to offset 0x0C whose data is a source number N below 64 clears enable bit N at that clock edge and changes no other enable bit.
- R4: A write to offset 0x08 or 0x0C whose full 32-bit data is 64 or more leaves every enable bit unchanged.
- R5: `irq_req` is high exactly when some source line is high and its enable bit is 1. It follows the source level with no latching, so it falls as soon as the enabled sources go low.
- R6: Offset 0x10 reads the lowest source number that is both high and enabled, in bits [5:0], with bit 31 at 0. When no such source exists it reads 0x8000_0000.
- R7: Offset 0x00 reads enable bits 31..0 and offset 0x04 reads enable bits 63..32, with enable bit N at word bit N mod 32.
- R8: Writes to any offset other than 0x08 and 0x0C leave every enable bit unchanged. Reads of unmapped offsets return 0.
- R9: Clearing the enable of the only pending source through 0x0C drops `irq_req` from the clock edge of that write, even while the source line stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data (source number for the set and clear registers) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_lvl | input | 64 | Level-sensitive interrupt source lines, active high |
| irq_req | output | 1 | Combined request: any enabled source high |

## Verification
The assertions assume a single-port bus, so at most one set or clear command arrives per cycle. They also assume the source lines are synchronous to `clk`, so a line never changes between the edge and the sampling of the first-pending result. The stimulus changes the bus and the source lines only just after a rising edge and holds them for a full cycle. The random phase draws indices from a range slightly wider than the source count, so the out-of-range case is exercised. Writes to the read-only words are mixed in as well.

// File: rtl/idx_irq_pkg.sv
package idx_irq_pkg;

  localparam logic [7:0] OFS_EN_LO = 8'h00;
  localparam logic [7:0] OFS_EN_HI = 8'h04;
  localparam logic [7:0] OFS_SET   = 8'h08;
  localparam logic [7:0] OFS_CLR   = 8'h0C;
  localparam logic [7:0] OFS_FIRST = 8'h10;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } en_op_e;

endpackage

// File: rtl/idx_irq_rst_sync.sv
module idx_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/idx_irq_enables.sv
module idx_irq_enables
  import idx_irq_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NSRC-1:0]   en_q
);

  en_op_e          op;
  logic            in_range;
  logic [IDX_W-1:0] idx;
  logic            en_we;
  logic [NSRC-1:0] en_d;

  // Command decode
  always_comb begin
    in_range = (bus_wdata < DATA_W'(NSRC));
    idx      = bus_wdata[IDX_W-1:0];
    op       = OP_NONE;
    if (bus_wr && in_range) begin
      if (bus_addr == ADDR_W'(OFS_SET))      op = OP_SET;
      else if (bus_addr == ADDR_W'(OFS_CLR)) op = OP_CLR;
    end
  end

  // Next state
  always_comb begin
    en_d  = en_q;
    en_we = 1'b0;
    unique case (op)
      OP_SET: begin
        en_d[idx] = 1'b1;
        en_we     = 1'b1;
      end
      OP_CLR: begin
        en_d[idx] = 1'b0;
        en_we     = 1'b1;
      end
      default: ;
    endcase
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  // R2
  set_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> en_q[$past(idx)]);

  // R3
  clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> !en_q[$past(idx)]);

  // R2 R3
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_q ^ $past(en_q)) <= 1);

  // R4
  oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_range &&
     (bus_addr == ADDR_W'(OFS_SET) || bus_addr == ADDR_W'(OFS_CLR)))
    |=> $stable(en_q));

  // R8
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr ||
     (bus_addr != ADDR_W'(OFS_SET) && bus_addr != ADDR_W'(OFS_CLR)))
    |=> $stable(en_q));

endmodule

// File: rtl/idx_irq_first.sv
module idx_irq_first #(
  parameter int NSRC   = 64,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  act,
  output logic [IDX_W-1:0] first_idx,
  output logic             first_none
);

  // Lowest set bit wins: scan from the top so lower indices override
  always_comb begin
    first_idx  = '0;
    first_none = 1'b1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) begin
        first_idx  = IDX_W'(i);
        first_none = 1'b0;
      end
    end
  end

endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl
  import idx_irq_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NSRC),
  localparam int PAD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_lvl,
  output logic              irq_req
);

  logic             rst_n_int;
  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  act;
  logic [IDX_W-1:0] first_idx;
  logic             first_none;
  logic [PAD_W-1:0] en_pad;

  idx_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  idx_irq_enables #(
    .NSRC   (NSRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_en (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q)
  );

  assign act     = src_lvl & en_q;
  assign irq_req = |act;

  idx_irq_first #(
    .NSRC (NSRC)
  ) u_first (
    .act        (act),
    .first_idx  (first_idx),
    .first_none (first_none)
  );

  assign en_pad = PAD_W'(en_q);

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_EN_LO): bus_rdata = en_pad[DATA_W-1:0];
      ADDR_W'(OFS_EN_HI): bus_rdata = en_pad[PAD_W-1:DATA_W];
      ADDR_W'(OFS_FIRST): begin
        bus_rdata = DATA_W'(first_idx);
        bus_rdata[DATA_W-1] = first_none;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R5
  req_match_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_req == !first_none);

  // R6
  first_hit_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !first_none |-> (src_lvl[first_idx] && en_q[first_idx]));

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && bus_addr == ADDR_W'(OFS_CLR) && !first_none &&
     bus_wdata == DATA_W'(first_idx) &&
     $countones(act) == 1) |=> !irq_req || $changed(src_lvl));

endmodule

// File: tb/idx_irq_ctrl_bench.sv
module idx_irq_ctrl_bench;

  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] src_lvl;
  logic        irq_req;

  idx_irq_ctrl u_idx_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_lvl   (src_lvl),
    .irq_req   (irq_req)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] m_en;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  function automatic logic [31:0] exp_first(logic [63:0] a);
    logic [31:0] r = 32'h8000_0000;
    for (int i = 63; i >= 0; i--) if (a[i]) r = 32'(i);
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00:   return m_en[31:0];
      8'h04:   return m_en[63:32];
      8'h10:   return exp_first(m_en & src_lvl);
      default: return 32'h0;
    endcase
  endfunction

  // Monitor: pops expected items and compares
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      exp_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (bus_rdata !== it.rd || irq_req !== it.irq) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.tag, bus_rdata, irq_req, it.rd, it.irq);
      end
    end
  end

  task automatic rd_chk(input logic [7:0] a, input string tag);
    exp_t it;
    @(posedge clk); #1;
    bus_addr = a;
    bus_wr   = 1'b0;
    it.rd  = exp_rd(a);
    it.irq = |(m_en & src_lvl);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_all(input string tag);
    rd_chk(8'h00, tag);
    rd_chk(8'h04, tag);
    rd_chk(8'h10, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr  = a;
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    if (d < 32'd64) begin
      if (a == 8'h08) m_en[d[5:0]] = 1'b1;
      if (a == 8'h0C) m_en[d[5:0]] = 1'b0;
    end
  endtask

  task automatic drive_src(input logic [63:0] v);
    @(posedge clk); #1;
    src_lvl = v;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_addr  = 8'h00;
    bus_wr    = 1'b0;
    bus_wdata = 32'h0;
    src_lvl   = '1;
    m_en      = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state with all sources high
    chk_all("R1 reset");

    // R2 set individual indices, R7 word placement
    wr(8'h08, 32'd5);   chk_all("R2 set 5");
    wr(8'h08, 32'd40);  chk_all("R2 R7 set 40");
    wr(8'h08, 32'd63);  chk_all("R7 set 63");
    wr(8'h08, 32'd0);   chk_all("R2 set 0");

    // R4 out-of-range indices
    wr(8'h08, 32'd64);          chk_all("R4 set 64");
    wr(8'h08, 32'hFFFF_FFFF);   chk_all("R4 set max");
    wr(8'h0C, 32'h0000_0100);   chk_all("R4 clr 256");
    wr(8'h0C, 32'h4000_0005);   chk_all("R4 clr alias of 5");

    // R8 writes to read-only / unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF);   chk_all("R8 wr enlo");
    wr(8'h10, 32'd7);           chk_all("R8 wr first");
    wr(8'h20, 32'd9);           rd_chk(8'h20, "R8 unmapped read");

    // R5 R6 source patterns
    drive_src(64'h0);                    chk_all("R5 no src");
    drive_src(64'h0000_0100_0000_0000);  chk_all("R5 R6 src 40");
    drive_src(64'h8000_0000_0000_0020);  chk_all("R6 src 5 and 63");
    drive_src(64'h8000_0000_0000_0000);  chk_all("R6 src 63");
    drive_src(64'h0000_0000_0000_0002);  chk_all("R5 disabled src 1");

    // R3 R9 acknowledge by clearing the only pending source
    drive_src(64'h0000_0000_0000_0020);  chk_all("R9 pending 5");
    wr(8'h0C, 32'd5);                    chk_all("R3 R9 clr 5");
    drive_src('1);                       chk_all("R3 all high");
    wr(8'h0C, 32'd0);                    chk_all("R3 clr 0 first moves");

    // Random phase
    for (int k = 0; k < 300; k++) begin
      int unsigned sel = $urandom_range(0, 5);
      logic [31:0] ix  = 32'($urandom_range(0, 70));
      case (sel)
        0, 1: wr(8'h08, ix);
        2, 3: wr(8'h0C, ix);
        4:    wr(8'($urandom_range(0, 5) * 4), ix);
        default: drive_src({$urandom, $urandom} & {$urandom, $urandom});
      endcase
      chk_all("R2 R3 R4 R5 R6 R7 R8 random");
    end

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule